// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the state of one downstream port on the root hub of a full/low-speed USB host controller. Host software reads and writes it as a 16-bit word. The device side reports attach and detach events and the speed of the device. The block keeps these facts in the register:

- whether a device is connected;
- whether the port is enabled;
- two sticky change flags, one for connect and one for enable;
- a low-speed indication;
- a software-driven bus-reset bit.

Host software acknowledges a change flag by writing a one to it. Setting the reset bit from zero to one produces a single-cycle request, which the line-signalling logic uses to reset the device on the bus.

The packet engine delivers transactions only to a port whose `port_enabled` output is high. The block is instantiated once for each port, typically twice. An instance built with `IMPLEMENTED = 0` stands in for a port index that does not exist. It reads as a fixed idle pattern and never enables.

Top module: `usb_root_port_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_data` is 0x0000, `port_enabled` is 0 and `bus_reset_req` is 0.
- R2: A write (`wr_en` high) updates the register at the next clock edge. Bit 2 (enabled) and bits 15..9 take the written value. Bit 0 (connected), bit 8 (low speed) and bits 7..4 keep their previous value, so bits 7..4 always read 0.
- R3: Bit 1 (connect changed) and bit 3 (enable changed) are write-one-to-clear. Writing 1 to either bit clears it. Writing 0 leaves it unchanged.
- R4: A write that sets bit 9 (bus reset) while it reads 0 makes `bus_reset_req` high for exactly the following cycle. A write of 1 while bit 9 is already 1 makes no request.
- R5: A `dev_attach` pulse has the following effects:
  - If bit 2 was set after the same cycle's write, bit 2 is cleared and bit 3 is set.
  - Bits 0 and 1 are set.
  - Bit 8 is loaded from `dev_lowspeed`.
  - For these bits the attach overrides a write in the same cycle.
- R6: A `dev_detach` pulse has the following effects:
  - If bit 0 is set, it is cleared and bit 1 is set.
  - If bit 2 is set, it is cleared and bit 3 is set.
  - A detach in the same cycle as an attach is treated as an attach.
- R7: `port_enabled` always equals bit 2 of `rd_data`. It changes on the same clock edge as the register.
- R8: A `hc_reset` cycle has the following effects:
  - The register is set to 0.
  - If a device is present (attached and not detached since, counting an attach in that same cycle), bits 0 and 1 are set and bit 8 is loaded from `dev_lowspeed`.
  - `hc_reset` overrides any write in the same cycle and produces no bus-reset request.
- R9: With `IMPLEMENTED = 0`, `rd_data` is always 0xFF7F, `port_enabled` is always 0 and `bus_reset_req` is always 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_reset | input | 1 | Controller-level reset, re-applies any present device |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| dev_attach | input | 1 | Device attach event (one cycle) |
| dev_detach | input | 1 | Device detach event (one cycle) |
| dev_lowspeed | input | 1 | Speed of the attaching device, 1 = low speed |
| port_enabled | output | 1 | Port may receive packets |
| bus_reset_req | output | 1 | One-cycle bus reset request |

## Verification
The bench sweeps every combination of the following and compares every cycle against an arithmetic model:
- connected, enabled and reset-bit starting states;
- both device speeds;
- 64 write patterns;
- four same-cycle events.

Several faults would show up in this sweep:
- A merge mask that lets software set the connect or speed bits would show them tracking the written data.
- A change bit cleared on a written zero would lose a pending attach notice.
- An attach that does not override a same-cycle acknowledge would leave the connect change flag clear after a plug-in.
- A request taken from the level of bit 9 instead of its rising edge would pulse on every rewrite of a port already in reset.
- A controller reset that forgets the present device would report an empty port until the next plug event.

// File: rtl/usb_root_port_reg.sv
module usb_root_port_reg #(
  parameter bit          IMPLEMENTED = 1'b1,
  parameter int          WIDTH       = 16,
  parameter logic [15:0] KEEP_MASK   = 16'h01FB,
  parameter logic [15:0] W1C_MASK    = 16'h000A,
  parameter logic [15:0] ABSENT_VAL  = 16'hFF7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_reset,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             dev_attach,
  input  logic             dev_detach,
  input  logic             dev_lowspeed,
  output logic             port_enabled,
  output logic             bus_reset_req
);

  localparam int B_CONN = 0;
  localparam int B_CCHG = 1;
  localparam int B_EN   = 2;
  localparam int B_ECHG = 3;
  localparam int B_LS   = 8;
  localparam int B_RST  = 9;

  generate
    if (IMPLEMENTED) begin : g_port
      logic [WIDTH-1:0] q, merged, nxt;
      logic             present, present_nxt, req_q;

      assign merged      = ((q & KEEP_MASK) | (wr_data & ~KEEP_MASK)) & ~(wr_data & W1C_MASK);
      assign present_nxt = dev_attach | (present & ~dev_detach);

      always_comb begin
        nxt = wr_en ? merged : q;
        if (hc_reset) begin
          nxt = '0;
          if (present_nxt) begin
            nxt[B_CONN] = 1'b1;
            nxt[B_CCHG] = 1'b1;
            nxt[B_LS]   = dev_lowspeed;
          end
        end else if (dev_attach) begin
          if (nxt[B_EN]) begin
            nxt[B_EN]   = 1'b0;
            nxt[B_ECHG] = 1'b1;
          end
          nxt[B_CONN] = 1'b1;
          nxt[B_CCHG] = 1'b1;
          nxt[B_LS]   = dev_lowspeed;
        end else if (dev_detach) begin
          if (nxt[B_CONN]) begin
            nxt[B_CONN] = 1'b0;
            nxt[B_CCHG] = 1'b1;
          end
          if (nxt[B_EN]) begin
            nxt[B_EN]   = 1'b0;
            nxt[B_ECHG] = 1'b1;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q       <= '0;
          present <= 1'b0;
          req_q   <= 1'b0;
        end else begin
          q       <= nxt;
          present <= present_nxt;
          req_q   <= ~hc_reset & wr_en & wr_data[B_RST] & ~q[B_RST];
        end
      end

      assign rd_data       = q;
      assign port_enabled  = q[B_EN];
      assign bus_reset_req = req_q;

      AST_REQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_req |-> ($past(wr_en) && $past(wr_data[B_RST]) && !$past(rd_data[B_RST]) && !$past(hc_reset))); // R4
      AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_req |=> !bus_reset_req); // R4
      AST_ATTACH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_attach && !hc_reset) |=> (rd_data[B_CONN] && rd_data[B_CCHG] && !port_enabled)); // R5
      AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_detach && !dev_attach && !hc_reset) |=> (!rd_data[B_CONN] && !port_enabled)); // R6
      AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dev_attach && !dev_detach && !hc_reset) |=>
          (rd_data[B_CONN] == $past(rd_data[B_CONN]) && rd_data[B_LS] == $past(rd_data[B_LS]))); // R2
      AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_CCHG] && !dev_attach && !dev_detach && !hc_reset) |=> !rd_data[B_CCHG]); // R3
      AST_HC_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset |=> (!port_enabled && !bus_reset_req)); // R8
      AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dev_attach && !dev_detach && !hc_reset) |=> (port_enabled == $past(wr_data[B_EN]))); // R7
    end else begin : g_absent
      assign rd_data       = ABSENT_VAL;
      assign port_enabled  = 1'b0;
      assign bus_reset_req = 1'b0;
    end
  endgenerate

endmodule

// File: tb/usb_root_port_reg_test.sv
`timescale 1ns/100ps
module usb_root_port_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hc_reset = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        dev_attach = 1'b0, dev_detach = 1'b0, dev_lowspeed = 1'b0;
  logic [15:0] rd_data, g_rd;
  logic        port_enabled, bus_reset_req, g_en, g_req;

  int checks = 0, fails = 0;
  logic [15:0] m_q = '0;
  logic        m_pres = 1'b0, m_req = 1'b0;

  always #2.5 clk = ~clk;

  usb_root_port_reg uut (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dev_attach(dev_attach), .dev_detach(dev_detach),
    .dev_lowspeed(dev_lowspeed), .port_enabled(port_enabled), .bus_reset_req(bus_reset_req));

  usb_root_port_reg #(.IMPLEMENTED(1'b0)) ghost (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(g_rd), .dev_attach(dev_attach), .dev_detach(dev_detach),
    .dev_lowspeed(dev_lowspeed), .port_enabled(g_en), .bus_reset_req(g_req));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [15:0] wd,
                     input logic att, input logic det, input logic ls, input logic hr);
    logic [15:0] n;
    logic        pn;
    wr_en = we; wr_data = wd; dev_attach = att; dev_detach = det;
    dev_lowspeed = ls; hc_reset = hr;
    n  = we ? (((m_q & 16'h01FB) | (wd & 16'hFE04)) & ~(wd & 16'h000A)) : m_q;
    pn = att | (m_pres & ~det);
    if (hr) begin
      n = pn ? {7'd0, ls, 6'd0, 2'b11} : 16'h0000;
    end else if (att) begin
      if (n[2]) n = (n & ~16'h0004) | 16'h0008;
      n = (n & ~16'h0100) | 16'h0003 | (16'(ls) << 8);
    end else if (det) begin
      if (n[0]) n = (n & ~16'h0001) | 16'h0002;
      if (n[2]) n = (n & ~16'h0004) | 16'h0008;
    end
    m_req  = !hr && we && wd[9] && !m_q[9];
    m_q    = n;
    m_pres = pn;
    @(negedge clk);
    chk(tag, rd_data, m_q);
    chk({tag, " R7 enable"}, {15'd0, port_enabled}, {15'd0, m_q[2]});
    chk({tag, " R4 request"}, {15'd0, bus_reset_req}, {15'd0, m_req});
    chk("R9 absent port", {g_rd[15:0]}, 16'hFF7F);
    chk("R9 absent outputs", {14'd0, g_en, g_req}, 16'h0000);
    wr_en = 1'b0; dev_attach = 1'b0; dev_detach = 1'b0; hc_reset = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    wr_en = 1'b1; wr_data = 16'hFFFF; dev_attach = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, 16'h0000);
    chk("R1 reset outputs", {14'd0, port_enabled, bus_reset_req}, 16'h0000);
    wr_en = 1'b0; dev_attach = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 16'h0000);

    cyc("R4 first set", 1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 pulse", {15'd0, bus_reset_req}, 16'h0001);
    cyc("R4 rewrite", 1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 no repeat", {15'd0, bus_reset_req}, 16'h0000);
    cyc("R4 idle", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 still no pulse", {15'd0, bus_reset_req}, 16'h0000);

    for (int st = 0; st < 8; st++) begin
      for (int ls = 0; ls < 2; ls++) begin
        for (int p = 0; p < 64; p++) begin
          for (int ev = 0; ev < 4; ev++) begin
            logic [15:0] wd;
            string tg;
            wd = {p[5] ? 6'b101001 : 6'b000000, p[3] ? 1'b1 : 1'b0, p[4] ? 1'b1 : 1'b0,
                  p[5] ? 4'hF : 4'h0, p[2] ? 1'b1 : 1'b0, p[1] ? 1'b1 : 1'b0,
                  p[0] ? 1'b1 : 1'b0, p[5] ? 1'b1 : 1'b0};
            cyc("R6 setup detach", 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
            cyc("R8 setup clear", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
            if (st[0]) cyc("R5 setup attach", 1'b0, 16'h0000, 1'b1, 1'b0, ls[0], 1'b0);
            cyc("R3 setup write", 1'b1, 16'h000A | (st[1] ? 16'h0004 : 16'h0) | (st[2] ? 16'h0200 : 16'h0),
                1'b0, 1'b0, 1'b0, 1'b0);
            case (ev)
              0: tg = "R2 R3 masked write";
              1: tg = "R5 attach with write";
              2: tg = "R6 detach with write";
              default: tg = "R8 controller reset with write";
            endcase
            cyc(tg, 1'b1, wd, ev == 1, ev == 2, ls[0], ev == 3);
            if (ev == 2 && p == 0) cyc("R6 both events as attach", 1'b0, 16'h0, 1'b1, 1'b1, ls[0], 1'b0);
          end
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule